// File: doc/BRIEF.md
# Prefixed Opcode Mode Decoder

This block sits beside the instruction fetch path of an 8-bit processor core. It watches the opcode byte stream and recognises the prefix sequences that switch the next opcode into an extended meaning. There are three extended meanings: 32-bit "quad" data operations, 32-bit-pointer "long" indirect addressing, and a combined mode that uses both. A prefix applies to one opcode only. The next byte that is not a prefix is classified, and the block returns to base mode.

For every byte that completes an instruction, the block produces one registered result. The result holds an operation class, an addressing-mode code, the two mode flags and an illegal flag. Unprefixed opcodes are not decoded here. They are tagged as base opcodes for the core's ordinary decoder. Operand fetch, address generation and the wide datapath lie outside the block.

Top module: `prefix_opcode_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and every result field is 0. The first byte then accepted is interpreted in base mode.
- R2: In base mode, a byte other than 0x42 or 0xEA produces a result one cycle after it is accepted. That result has out_op=0 (base class), out_amode=0, both mode flags 0, out_illegal=0, out_lone=0, and `out_byte` equal to the byte.
- R3: Two accepted 0x42 bytes in a row arm quad mode for the next opcode. Neither prefix byte produces a result.
- R4: 0xEA in base mode arms long mode. 0xEA accepted after 0x42 0x42 arms combined quad+long mode. None of these prefix bytes produces a result.
- R5: A single 0x42 followed by a byte other than 0x42 or 0xEA produces one base result for that byte, with out_lone=1 to mark the passed-through 0x42 ahead of it. A single 0x42 followed by 0xEA produces a base result with out_byte=0x42 and out_lone=0, then arms long mode.
- R6: Quad mode, columns x1/x5/x9/xD. The pair index hi>>1 selects the class: 1 or, 2 and, 3 eor, 4 adc, 5 st, 6 ld, 7 cp, 8 sbc. On even rows, x1 gives (zp,x) code 7, x5 gives zp code 2, and xD gives abs16 code 4. On odd rows, x1 gives (zp),y code 8, x5 gives zp,x code 3, x9 gives abs16,y code 6, and xD gives abs16,x code 5.
- R7: Quad mode, column x2. Odd rows give the pair class with (zp) code 9. 0x82 gives st and 0xE2 gives ld, both with stack-relative (zp,s),y code 10.
- R8: Quad mode, columns x6/xE. For rows 0x0–0x7 the classes by pair are 9 asl, 10 rol, 11 lsr and 12 ror. Rows 0xC/0xD give 14 dec and rows 0xE/0xF give 13 inc. Column x6 gives zp (code 2) on even rows and zp,x (code 3) on odd rows. Column xE gives abs16 (code 4) on even rows and abs16,x (code 5) on odd rows. 0x0A/0x2A/0x4A/0x6A give the shift class with accumulator code 1. 0x1A gives inc on the accumulator and 0x3A gives dec on the accumulator.
- R9: Any quad-mode opcode not covered by R6–R8 is illegal. This includes the even-row x9 immediate slots.
- R10: In long mode, opcodes with low nibble 2 and odd high nibble give the pair class with out_quad=0 and amode 12 (32-bit pointer, Z index). Every other opcode is illegal.
- R11: In combined mode, the same eight opcodes give the pair class with out_quad=1, out_long=1 and amode 11 (32-bit pointer, no index). Every other opcode is illegal.
- R12: After any prefixed result, legal or illegal, the following byte is interpreted in base mode.
- R13: An illegal result has out_illegal=1, out_op=15 and out_amode=0, and its mode flags show the mode that was armed.
- R14: `out_valid` is high for exactly one cycle, in the cycle after an accepted byte that completes an instruction. Bytes presented with `in_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Opcode or prefix byte |
| out_valid | output | 1 | Result strobe |
| out_byte | output | 8 | Opcode the result describes |
| out_op | output | 4 | Operation class code |
| out_amode | output | 4 | Addressing-mode code |
| out_quad | output | 1 | Quad data mode was armed |
| out_long | output | 1 | Long pointer mode was armed |
| out_illegal | output | 1 | Opcode not allowed in the armed mode |
| out_lone | output | 1 | A lone 0x42 precedes this base opcode |

## Verification
The assertions assume that reset is held for at least one clock with `in_valid` low, and that `in_valid` is never unknown outside reset. The bench drives its bytes on the falling edge and lowers `in_valid` only during reset and in deliberate idle gaps. During those gaps `in_byte` carries junk, often prefix values, to show that it is ignored. Each opcode is swept under every prefix, and a biased random stream then exercises chains of prefixes that mix with one another.

// File: rtl/pfxdec_pkg.sv
package pfxdec_pkg;

    typedef enum logic [3:0] {
        OPC_BASE = 4'd0,
        OPC_OR   = 4'd1,
        OPC_AND  = 4'd2,
        OPC_EOR  = 4'd3,
        OPC_ADC  = 4'd4,
        OPC_ST   = 4'd5,
        OPC_LD   = 4'd6,
        OPC_CP   = 4'd7,
        OPC_SBC  = 4'd8,
        OPC_ASL  = 4'd9,
        OPC_ROL  = 4'd10,
        OPC_LSR  = 4'd11,
        OPC_ROR  = 4'd12,
        OPC_INC  = 4'd13,
        OPC_DEC  = 4'd14,
        OPC_BAD  = 4'd15
    } op_class_e;

    typedef enum logic [3:0] {
        AM_NONE   = 4'd0,
        AM_ACC    = 4'd1,
        AM_ZP     = 4'd2,
        AM_ZPX    = 4'd3,
        AM_ABS    = 4'd4,
        AM_ABSX   = 4'd5,
        AM_ABSY   = 4'd6,
        AM_IZX    = 4'd7,
        AM_IZY    = 4'd8,
        AM_IZ     = 4'd9,
        AM_ISY    = 4'd10,
        AM_IND32  = 4'd11,
        AM_IND32Z = 4'd12
    } amode_e;

    typedef enum logic [2:0] {
        PS_BASE,
        PS_HALF,
        PS_QUAD,
        PS_LONG,
        PS_QLONG
    } pfx_state_e;

    typedef struct packed {
        logic quad;
        logic lng;
    } mode_t;

    typedef struct packed {
        op_class_e op;
        amode_e    am;
        logic      bad;
    } dec_t;

    localparam dec_t DEC_BAD  = '{op: OPC_BAD,  am: AM_NONE, bad: 1'b1};
    localparam dec_t DEC_BASE = '{op: OPC_BASE, am: AM_NONE, bad: 1'b0};

    // Pair index of the high nibble -> load/store/arithmetic class
    function automatic op_class_e group_op(input logic [2:0] pair);
        return op_class_e'(4'(pair) + 4'd1);
    endfunction

    // Pair index within rows 0x0-0x7 -> shift/rotate class
    function automatic op_class_e shift_op(input logic [1:0] pair);
        return op_class_e'(4'(pair) + 4'd9);
    endfunction

    function automatic dec_t mk(input op_class_e op, input amode_e am);
        return '{op: op, am: am, bad: 1'b0};
    endfunction

endpackage

// File: rtl/pfxdec_tracker.sv
module pfxdec_tracker
    import pfxdec_pkg::*;
#(
    parameter logic [7:0] QUAD_PFX = 8'h42,
    parameter logic [7:0] LONG_PFX = 8'hEA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic [7:0] data,
    output logic       emit,
    output logic [7:0] emit_byte,
    output mode_t      mode,
    output logic       lone
);

    pfx_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        emit      = 1'b0;
        emit_byte = data;
        mode      = '0;
        lone      = 1'b0;
        if (valid) begin
            case (state)
                PS_BASE: begin
                    if (data == QUAD_PFX)      state_nxt = PS_HALF;
                    else if (data == LONG_PFX) state_nxt = PS_LONG;
                    else                       emit = 1'b1;
                end
                PS_HALF: begin
                    if (data == QUAD_PFX) begin
                        state_nxt = PS_QUAD;
                    end else if (data == LONG_PFX) begin
                        emit      = 1'b1;
                        emit_byte = QUAD_PFX;
                        state_nxt = PS_LONG;
                    end else begin
                        emit      = 1'b1;
                        lone      = 1'b1;
                        state_nxt = PS_BASE;
                    end
                end
                PS_QUAD: begin
                    if (data == LONG_PFX) begin
                        state_nxt = PS_QLONG;
                    end else begin
                        emit      = 1'b1;
                        mode.quad = 1'b1;
                        state_nxt = PS_BASE;
                    end
                end
                PS_LONG: begin
                    emit      = 1'b1;
                    mode.lng  = 1'b1;
                    state_nxt = PS_BASE;
                end
                PS_QLONG: begin
                    emit      = 1'b1;
                    mode.quad = 1'b1;
                    mode.lng  = 1'b1;
                    state_nxt = PS_BASE;
                end
                default: state_nxt = PS_BASE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_BASE;
        else     state <= state_nxt;
    end

endmodule

// File: rtl/pfxdec_quad_table.sv
module pfxdec_quad_table
    import pfxdec_pkg::*;
(
    input  logic [7:0] opc,
    output dec_t       res
);

    logic [3:0] hi, lo;
    logic       odd;
    logic [2:0] pair;
    amode_e     rmw_am;

    assign hi     = opc[7:4];
    assign lo     = opc[3:0];
    assign odd    = hi[0];
    assign pair   = hi[3:1];
    assign rmw_am = lo[3] ? (odd ? AM_ABSX : AM_ABS) : (odd ? AM_ZPX : AM_ZP);

    always_comb begin
        res = DEC_BAD;
        case (lo)
            4'h1: res = mk(group_op(pair), odd ? AM_IZY : AM_IZX);
            4'h5: res = mk(group_op(pair), odd ? AM_ZPX : AM_ZP);
            4'h9: if (odd) res = mk(group_op(pair), AM_ABSY);
            4'hD: res = mk(group_op(pair), odd ? AM_ABSX : AM_ABS);
            4'h2: begin
                if (odd)               res = mk(group_op(pair), AM_IZ);
                else if (opc == 8'h82) res = mk(OPC_ST, AM_ISY);
                else if (opc == 8'hE2) res = mk(OPC_LD, AM_ISY);
            end
            4'h6, 4'hE: begin
                if (!hi[3])    res = mk(shift_op(hi[2:1]), rmw_am);
                else if (hi[2]) res = mk(hi[1] ? OPC_INC : OPC_DEC, rmw_am);
            end
            4'hA: begin
                if (!hi[3] && !odd)    res = mk(shift_op(hi[2:1]), AM_ACC);
                else if (opc == 8'h1A) res = mk(OPC_INC, AM_ACC);
                else if (opc == 8'h3A) res = mk(OPC_DEC, AM_ACC);
            end
            default: res = DEC_BAD;
        endcase
    end

endmodule

// File: rtl/pfxdec_long_table.sv
module pfxdec_long_table
    import pfxdec_pkg::*;
(
    input  logic [7:0] opc,
    input  logic       wide,
    output dec_t       res
);

    always_comb begin
        if (opc[3:0] == 4'h2 && opc[4])
            res = mk(group_op(opc[7:5]), wide ? AM_IND32 : AM_IND32Z);
        else
            res = DEC_BAD;
    end

endmodule

// File: rtl/prefix_opcode_decoder.sv
module prefix_opcode_decoder
    import pfxdec_pkg::*;
#(
    parameter logic [7:0] QUAD_PFX = 8'h42,
    parameter logic [7:0] LONG_PFX = 8'hEA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic [3:0] out_op,
    output logic [3:0] out_amode,
    output logic       out_quad,
    output logic       out_long,
    output logic       out_illegal,
    output logic       out_lone
);

    logic       emit, lone;
    logic [7:0] emit_byte;
    mode_t      mode;
    dec_t       quad_res, long_res, sel;

    pfxdec_tracker #(.QUAD_PFX(QUAD_PFX), .LONG_PFX(LONG_PFX)) u_tracker (
        .clk(clk), .rst(rst), .valid(in_valid), .data(in_byte),
        .emit(emit), .emit_byte(emit_byte), .mode(mode), .lone(lone)
    );

    pfxdec_quad_table u_quad (.opc(emit_byte), .res(quad_res));

    pfxdec_long_table u_long (.opc(emit_byte), .wide(mode.quad), .res(long_res));

    always_comb begin
        if (mode.lng)       sel = long_res;
        else if (mode.quad) sel = quad_res;
        else                sel = DEC_BASE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_byte    <= '0;
            out_op      <= '0;
            out_amode   <= '0;
            out_quad    <= 1'b0;
            out_long    <= 1'b0;
            out_illegal <= 1'b0;
            out_lone    <= 1'b0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_byte    <= emit_byte;
                out_op      <= sel.op;
                out_amode   <= sel.am;
                out_quad    <= mode.quad;
                out_long    <= mode.lng;
                out_illegal <= sel.bad;
                out_lone    <= lone;
            end
        end
    end

endmodule

// File: rtl/pfxdec_checks.sv
module pfxdec_checks
    import pfxdec_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       out_valid,
    input logic [3:0] out_op,
    input logic [3:0] out_amode,
    input logic       out_quad,
    input logic       out_long,
    input logic       out_illegal,
    input logic       out_lone
);

    assert_illegal_fields_R13: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_op == OPC_BAD && out_amode == AM_NONE));

    assert_base_legal_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_quad && !out_long) |-> (!out_illegal && out_op == OPC_BASE));

    assert_long_amode_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_long && !out_quad && !out_illegal) |-> out_amode == AM_IND32Z);

    assert_qlong_amode_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_long && out_quad && !out_illegal) |-> out_amode == AM_IND32);

    assert_lone_base_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_lone) |-> (!out_quad && !out_long));

    assert_valid_cause_R14: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

endmodule

bind prefix_opcode_decoder pfxdec_checks u_checks (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_op(out_op), .out_amode(out_amode), .out_quad(out_quad),
    .out_long(out_long), .out_illegal(out_illegal), .out_lone(out_lone)
);

// File: tb/tb_prefix_opcode_decoder.sv
module tb_prefix_opcode_decoder;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, in_valid;
    logic [7:0] in_byte;
    logic       out_valid, out_quad, out_long, out_illegal, out_lone;
    logic [7:0] out_byte;
    logic [3:0] out_op, out_amode;

    prefix_opcode_decoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .out_op(out_op),
        .out_amode(out_amode), .out_quad(out_quad), .out_long(out_long),
        .out_illegal(out_illegal), .out_lone(out_lone)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // model state: 0 base, 1 one 0x42 seen, 2 quad, 3 long, 4 quad+long
    int    mstate = 0;
    bit    after_pref = 0;
    bit    e_valid, e_q, e_l, e_ill, e_lone;
    int    e_op, e_am;
    logic [7:0] e_byte;
    string e_tag;

    task automatic ref_decode(input int md, input logic [7:0] b,
                              output int op, output int am);
        int h, l, grp, odd;
        h = int'(b[7:4]); l = int'(b[3:0]); grp = h / 2; odd = h % 2;
        op = 15; am = 0;
        if (md == 1) begin
            if (l == 1) begin op = 1 + grp; am = odd ? 8 : 7; end
            else if (l == 5) begin op = 1 + grp; am = odd ? 3 : 2; end
            else if (l == 9 && odd == 1) begin op = 1 + grp; am = 6; end
            else if (l == 13) begin op = 1 + grp; am = odd ? 5 : 4; end
            else if (l == 2) begin
                if (odd == 1)        begin op = 1 + grp; am = 9; end
                else if (b == 8'h82) begin op = 5; am = 10; end
                else if (b == 8'hE2) begin op = 6; am = 10; end
            end else if (l == 6 || l == 14) begin
                int a;
                a = (l == 6) ? (odd ? 3 : 2) : (odd ? 5 : 4);
                if (h < 8)        begin op = 9 + h / 2; am = a; end
                else if (h >= 12) begin op = (h >= 14) ? 13 : 14; am = a; end
            end else if (l == 10) begin
                if (h < 8 && odd == 0) begin op = 9 + h / 2; am = 1; end
                else if (b == 8'h1A)   begin op = 13; am = 1; end
                else if (b == 8'h3A)   begin op = 14; am = 1; end
            end
        end else if (l == 2 && odd == 1) begin
            op = 1 + grp; am = (md == 3) ? 11 : 12;
        end
    endtask

    task automatic emit_base(input logic [7:0] b, input bit lone_f);
        e_valid = 1; e_byte = b; e_op = 0; e_am = 0; e_q = 0; e_l = 0;
        e_ill = 0; e_lone = lone_f;
        e_tag = lone_f ? "R5" : (after_pref ? "R12" : "R2");
        after_pref = 0;
    endtask

    task automatic emit_pref(input int md, input logic [7:0] b);
        int op, am;
        ref_decode(md, b, op, am);
        e_valid = 1; e_byte = b; e_op = op; e_am = am; e_lone = 0;
        e_q = (md != 2); e_l = (md != 1); e_ill = (op == 15);
        if (md == 2)       e_tag = "R10";
        else if (md == 3)  e_tag = "R11";
        else if (e_ill)    e_tag = "R9";
        else if (b[3:0] == 4'h2) e_tag = "R7";
        else if (b[3:0] == 4'h6 || b[3:0] == 4'hA || b[3:0] == 4'hE) e_tag = "R8";
        else               e_tag = "R6";
        after_pref = 1;
    endtask

    task automatic compare();
        bit bad;
        n_tests++;
        bad = (out_valid !== e_valid);
        if (!bad && e_valid)
            bad = (out_byte !== e_byte) || (int'(out_op) != e_op) ||
                  (int'(out_amode) != e_am) || (out_quad !== e_q) ||
                  (out_long !== e_l) || (out_illegal !== e_ill) ||
                  (out_lone !== e_lone);
        if (bad) begin
            n_fail++;
            $display("FAIL %s: got v=%0b byte=%02h op=%0d am=%0d q=%0b l=%0b ill=%0b lone=%0b exp v=%0b byte=%02h op=%0d am=%0d q=%0b l=%0b ill=%0b lone=%0b",
                     e_tag, out_valid, out_byte, out_op, out_amode, out_quad, out_long,
                     out_illegal, out_lone, e_valid, e_byte, e_op, e_am, e_q, e_l,
                     e_ill, e_lone);
        end
    endtask

    // Drive at a falling edge, let the rising edge capture, check at the next falling edge.
    task automatic step(input bit v, input logic [7:0] b);
        in_valid = v; in_byte = b;
        e_valid = 0; e_tag = "R14";
        if (v) begin
            case (mstate)
                0: if (b == 8'h42) begin mstate = 1; e_tag = "R3"; end
                   else if (b == 8'hEA) begin mstate = 3; e_tag = "R4"; end
                   else emit_base(b, 0);
                1: if (b == 8'h42) begin mstate = 2; e_tag = "R3"; end
                   else if (b == 8'hEA) begin emit_base(8'h42, 0); e_tag = "R5"; mstate = 3; end
                   else begin emit_base(b, 1); mstate = 0; end
                2: if (b == 8'hEA) begin mstate = 4; e_tag = "R4"; end
                   else begin emit_pref(1, b); mstate = 0; end
                3: begin emit_pref(2, b); mstate = 0; end
                default: begin emit_pref(3, b); mstate = 0; end
            endcase
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got running exp finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1; in_valid = 0; in_byte = 8'h42;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        n_tests++;
        if (out_valid !== 0 || out_byte !== 0 || out_op !== 0 || out_amode !== 0 ||
            out_quad !== 0 || out_long !== 0 || out_illegal !== 0 || out_lone !== 0) begin
            n_fail++;
            $display("FAIL R1: got v=%0b op=%0d am=%0d exp all zero", out_valid, out_op, out_amode);
        end
        step(1, 8'h09);           // R1: first byte base

        for (int op = 0; op < 256; op++) begin
            step(1, 8'h42); step(1, 8'h42); step(1, 8'(op));
            step(0, 8'h42);
            step(1, 8'hEA); step(1, 8'(op));
            step(1, 8'h42); step(1, 8'h42); step(1, 8'hEA); step(1, 8'(op));
            if (op != 8'h42 && op != 8'hEA) step(1, 8'(op));
            step(0, 8'hEA);
        end

        // R5: lone prefix forms
        step(1, 8'h42); step(1, 8'h10);
        step(1, 8'h42); step(1, 8'hEA); step(1, 8'h12);

        // R13: illegal immediate slot fields, checked directly
        step(1, 8'h42); step(1, 8'h42); step(1, 8'h89);
        n_tests++;
        if (out_illegal !== 1 || out_op !== 4'd15 || out_amode !== 4'd0 || out_quad !== 1) begin
            n_fail++;
            $display("FAIL R13: got ill=%0b op=%0d am=%0d q=%0b exp 1 15 0 1",
                     out_illegal, out_op, out_amode, out_quad);
        end
        step(1, 8'h89);           // R12: back to base after illegal

        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [7:0] b;
            r = $urandom % 8;
            b = (r < 2) ? 8'h42 : (r == 2) ? 8'hEA : 8'($urandom);
            step(($urandom % 5) != 0, b);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule